// File: doc/BRIEF.md
# Oversampled Manchester Line Decoder

This block turns a Manchester-coded serial line into NRZ bits and a recovered bit clock. One sample is taken per clock cycle, at 16 or 32 samples per bit. The line first passes a two-flop synchronizer. A span counter then measures the number of samples between consecutive line transitions. Each span is sorted into one of three classes: a half-bit span, a full-bit span, or a one-and-a-half-bit span. The last class is reserved for framing, because valid data can never hold a level that long.

A framing span locks the decoder, and the transition that ends it is taken as a bit boundary. From that reference, a small state machine tells mid-bit edges from boundary edges. Each mid-bit edge yields one data bit: a rising edge gives 0 and a falling edge gives 1. A phase counter restarts on every decoded mid-bit edge and produces the recovered clock. When no edges arrive, the counter keeps running at the bit period. A framing span raises a sync flag and records which level it held. A span that cannot belong to valid data raises a violation flag and drops lock until the next framing span.

Top module: `mdec_top`

## Requirements
- R1: With `rate_wide` low, one bit period is 16 samples and every span tolerance is ±2 samples. With it high, the bit period is 32 samples and the tolerance is ±6. `rate_wide` is changed only while `rst` is high.
- R2: A span within half a bit period ± tolerance is a short span. A frame whose spans sit at the tolerance extremes decodes with no violation.
- R3: A full-bit span ± tolerance that starts at a mid-bit edge ends at the next mid-bit edge, so the bit value changes.
- R4: A span of 1.5 bit periods ± tolerance locks the decoder, and its ending edge counts as a bit boundary. `sync_flag` goes high for one bit period. `sync_pol` takes the level held during the span (1 = high) and changes at no other time.
- R5: While locked, each mid-bit edge updates `nrz_data`: a rising edge gives 0 and a falling edge gives 1. This happens 3 clocks after the line change. A short span starting at a boundary ends at a mid-bit edge. A short span starting at a mid-bit edge ends at a boundary and decodes nothing.
- R6: While locked, a span outside all three windows, or a full-bit span starting at a boundary, sets `viol_flag` for one bit period and drops lock.
- R7: `dclk` is high during the first half of each bit period. Its phase restarts at every decoded mid-bit edge, and otherwise it runs freely with the bit period. `nrz_data` changes only while `dclk` is high.
- R8: A line held static leaves `nrz_data`, `sync_pol` and the flags unchanged. The span counter saturates instead of wrapping.
- R9: Synchronous reset clears `nrz_data`, both flags, `sync_pol`, the lock and the phase (`dclk` reads 1). It also saturates the span counter, so the first edge after reset never forms a valid span.
- R10: While unlocked, short, long and invalid spans are neither decoded nor flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, 16 or 32 times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| rate_wide | input | 1 | 0: 16 samples per bit, 1: 32 samples per bit |
| line_in | input | 1 | Asynchronous Manchester line |
| nrz_data | output | 1 | Decoded bit, updated at each mid-bit edge |
| dclk | output | 1 | Recovered bit clock |
| sync_flag | output | 1 | High for one bit period after a framing span |
| sync_pol | output | 1 | Level held during the last framing span |
| viol_flag | output | 1 | High for one bit period after a code violation |

## Verification
A line change driven before clock edge P reaches the synchronizer output at P+1. It is seen as an edge at P+2, where the decoded bit, the sync flag and polarity, the violation flag and the phase restart all register, so each result is due three clock edges after the change. The flags then remain high for exactly one bit period. The reference model keeps the last four line samples and classifies the transition between the two oldest, which reproduces that three-edge delay without copying the synchronizer. Every output is compared half a cycle after each edge, and directed checks read flags and data only once the three-edge delay has elapsed.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    typedef enum logic [2:0] {
        SPAN_NONE,
        SPAN_HALF,
        SPAN_FULL,
        SPAN_SYNC,
        SPAN_BAD
    } span_e;

    typedef struct packed {
        logic bit_strobe;
        logic bit_val;
        logic sync_strobe;
        logic sync_high;
        logic viol_strobe;
    } fsm_out_t;

    function automatic logic in_window(input int span, input int nominal, input int tol);
        return (span >= nominal - tol) && (span <= nominal + tol);
    endfunction

endpackage

// File: rtl/mdec_line_sync.sv
module mdec_line_sync (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic edge_seen,
    output logic level_before
);
    logic [1:0] meta;
    logic       last;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            last <= 1'b0;
        end else begin
            meta <= {meta[0], line_in};
            last <= meta[1];
        end
    end

    assign edge_seen    = meta[1] ^ last;
    assign level_before = last;
endmodule

// File: rtl/mdec_span_meter.sv
module mdec_span_meter
    import mdec_pkg::*;
#(
    parameter int SPAN_W = 6,
    parameter int BP_N   = 16,
    parameter int TOL_N  = 2,
    parameter int TOL_W  = 6
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wide,
    input  logic  edge_seen,
    output span_e kind
);
    localparam logic [SPAN_W-1:0] SPAN_TOP = '1;

    logic [SPAN_W-1:0] cnt;
    int   bp;
    int   tl;
    int   span;
    logic hit_half;
    logic hit_full;
    logic hit_sync;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= SPAN_TOP;
        else if (edge_seen)
            cnt <= SPAN_W'(1);
        else if (cnt != SPAN_TOP)
            cnt <= cnt + 1'b1;
    end

    always_comb begin
        bp       = wide ? 2 * BP_N : BP_N;
        tl       = wide ? TOL_W : TOL_N;
        span     = int'(cnt);
        hit_half = in_window(span, bp / 2, tl);
        hit_full = in_window(span, bp, tl);
        hit_sync = in_window(span, (3 * bp) / 2, tl);
        if (!edge_seen)
            kind = SPAN_NONE;
        else if (hit_half)
            kind = SPAN_HALF;
        else if (hit_full)
            kind = SPAN_FULL;
        else if (hit_sync)
            kind = SPAN_SYNC;
        else
            kind = SPAN_BAD;
    end

    AST_WINDOWS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit_half, hit_full, hit_sync})); // R2
endmodule

// File: rtl/mdec_frame_fsm.sv
module mdec_frame_fsm
    import mdec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  span_e    kind,
    input  logic     level_before,
    output fsm_out_t evt,
    output logic     locked
);
    logic at_mid;
    logic locked_n;
    logic at_mid_n;

    always_comb begin
        evt      = '0;
        locked_n = locked;
        at_mid_n = at_mid;
        case (kind)
            SPAN_SYNC: begin
                locked_n        = 1'b1;
                at_mid_n        = 1'b0;
                evt.sync_strobe = 1'b1;
                evt.sync_high   = level_before;
            end
            SPAN_HALF: begin
                if (locked) begin
                    if (at_mid) begin
                        at_mid_n = 1'b0;
                    end else begin
                        evt.bit_strobe = 1'b1;
                        evt.bit_val    = level_before;
                        at_mid_n       = 1'b1;
                    end
                end
            end
            SPAN_FULL: begin
                if (locked) begin
                    if (at_mid) begin
                        evt.bit_strobe = 1'b1;
                        evt.bit_val    = level_before;
                    end else begin
                        evt.viol_strobe = 1'b1;
                        locked_n        = 1'b0;
                    end
                end
            end
            SPAN_BAD: begin
                if (locked) begin
                    evt.viol_strobe = 1'b1;
                    locked_n        = 1'b0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
            at_mid <= 1'b0;
        end else begin
            locked <= locked_n;
            at_mid <= at_mid_n;
        end
    end
endmodule

// File: rtl/mdec_clk_flags.sv
module mdec_clk_flags
    import mdec_pkg::*;
#(
    parameter int BP_N = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wide,
    input  fsm_out_t evt,
    output logic     nrz_data,
    output logic     dclk,
    output logic     sync_flag,
    output logic     sync_pol,
    output logic     viol_flag
);
    localparam int BP_W  = 2 * BP_N;
    localparam int PH_W  = $clog2(BP_W);
    localparam int TMR_W = $clog2(BP_W + 1);
    localparam int NFLAG = 2;

    int              bp;
    logic [PH_W-1:0] ph;
    logic [NFLAG-1:0] strobe;
    logic [NFLAG-1:0] held;

    assign bp = wide ? BP_W : BP_N;

    always_ff @(posedge clk) begin
        if (rst)
            ph <= '0;
        else if (evt.bit_strobe)
            ph <= '0;
        else if (int'(ph) == bp - 1)
            ph <= '0;
        else
            ph <= ph + 1'b1;
    end

    assign dclk = int'(ph) < bp / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            nrz_data <= 1'b0;
            sync_pol <= 1'b0;
        end else begin
            if (evt.bit_strobe)
                nrz_data <= evt.bit_val;
            if (evt.sync_strobe)
                sync_pol <= evt.sync_high;
        end
    end

    assign strobe = {evt.viol_strobe, evt.sync_strobe};

    for (genvar g = 0; g < NFLAG; g++) begin : g_stretch
        logic [TMR_W-1:0] tmr;
        always_ff @(posedge clk) begin
            if (rst)
                tmr <= '0;
            else if (strobe[g])
                tmr <= TMR_W'(bp);
            else if (tmr != '0)
                tmr <= tmr - 1'b1;
        end
        assign held[g] = (tmr != '0);
    end

    assign sync_flag = held[0];
    assign viol_flag = held[1];

    AST_NRZ_IN_HIGH_PHASE: assert property (@(posedge clk) disable iff (rst)
        !$stable(nrz_data) |-> dclk); // R7
    AST_POL_ONLY_ON_SYNC: assert property (@(posedge clk) disable iff (rst)
        !$stable(sync_pol) |-> sync_flag); // R4
endmodule

// File: rtl/mdec_top.sv
module mdec_top
    import mdec_pkg::*;
#(
    parameter int BP_NARROW  = 16,
    parameter int TOL_NARROW = 2,
    parameter int TOL_WIDE   = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic rate_wide,
    input  logic line_in,
    output logic nrz_data,
    output logic dclk,
    output logic sync_flag,
    output logic sync_pol,
    output logic viol_flag
);
    localparam int BP_WIDE = 2 * BP_NARROW;
    localparam int SPAN_W  = $clog2((3 * BP_WIDE) / 2 + TOL_WIDE + 2);

    logic     edge_seen;
    logic     level_before;
    span_e    kind;
    fsm_out_t evt;
    logic     locked;

    mdec_line_sync u_line (
        .clk          (clk),
        .rst          (rst),
        .line_in      (line_in),
        .edge_seen    (edge_seen),
        .level_before (level_before)
    );

    mdec_span_meter #(
        .SPAN_W (SPAN_W),
        .BP_N   (BP_NARROW),
        .TOL_N  (TOL_NARROW),
        .TOL_W  (TOL_WIDE)
    ) u_span (
        .clk       (clk),
        .rst       (rst),
        .wide      (rate_wide),
        .edge_seen (edge_seen),
        .kind      (kind)
    );

    mdec_frame_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .kind         (kind),
        .level_before (level_before),
        .evt          (evt),
        .locked       (locked)
    );

    mdec_clk_flags #(
        .BP_N (BP_NARROW)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .wide      (rate_wide),
        .evt       (evt),
        .nrz_data  (nrz_data),
        .dclk      (dclk),
        .sync_flag (sync_flag),
        .sync_pol  (sync_pol),
        .viol_flag (viol_flag)
    );

    AST_VIOL_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
        $rose(viol_flag) |-> !locked); // R6
    AST_SYNC_LOCKS: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_flag) |-> locked); // R4
    AST_DECODE_WHILE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        !$stable(nrz_data) |-> locked); // R10
endmodule

// File: tb/sim_mdec_top.sv
`timescale 1ns/1ps
module sim_mdec_top;
    logic clk = 1'b0;
    logic rst;
    logic rate_wide;
    logic line_in;
    logic nrz_data, dclk, sync_flag, sync_pol, viol_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    mdec_top u0 (
        .clk       (clk),
        .rst       (rst),
        .rate_wide (rate_wide),
        .line_in   (line_in),
        .nrz_data  (nrz_data),
        .dclk      (dclk),
        .sync_flag (sync_flag),
        .sync_pol  (sync_pol),
        .viol_flag (viol_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: four most recent line samples, time stamps of transitions
    bit m_s0, m_s1, m_s2, m_s3;
    int m_tk, m_last, m_ph, m_tsync, m_tviol;
    bit m_lock, m_mid, m_nrz, m_pol;

    function automatic bit near(input int v, input int nom, input int t);
        int d;
        d = v - nom;
        if (d < 0) d = -d;
        return d <= t;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s0 = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_tk = 0; m_last = -100000; m_ph = 0; m_tsync = 0; m_tviol = 0;
            m_lock = 0; m_mid = 0; m_nrz = 0; m_pol = 0;
        end else begin
            int bp, tl, span;
            bit ev_dec, ev_sync, ev_viol;
            bp = rate_wide ? 32 : 16;
            tl = rate_wide ? 6 : 2;
            ev_dec = 0; ev_sync = 0; ev_viol = 0;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = m_s0; m_s0 = line_in;
            if (m_s2 != m_s3) begin
                span   = (m_tk - 2) - m_last;
                m_last = m_tk - 2;
                if (near(span, bp / 2, tl)) begin
                    if (m_lock) begin
                        if (m_mid) m_mid = 0;
                        else begin ev_dec = 1; m_nrz = m_s3; m_mid = 1; end
                    end
                end else if (near(span, bp, tl)) begin
                    if (m_lock) begin
                        if (m_mid) begin ev_dec = 1; m_nrz = m_s3; end
                        else ev_viol = 1;
                    end
                end else if (near(span, (3 * bp) / 2, tl)) begin
                    ev_sync = 1; m_lock = 1; m_mid = 0; m_pol = m_s3;
                end else if (m_lock) begin
                    ev_viol = 1;
                end
                if (ev_viol) m_lock = 0;
            end
            if (ev_sync) m_tsync = bp; else if (m_tsync > 0) m_tsync--;
            if (ev_viol) m_tviol = bp; else if (m_tviol > 0) m_tviol--;
            if (ev_dec || m_ph == bp - 1) m_ph = 0; else m_ph++;
            m_tk++;
        end
    end

    // Compare every cycle, half a period after the edge
    int  vrise = 0;
    bit  pv_viol = 0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            int bp;
            bp = rate_wide ? 32 : 16;
            chk("R5 nrz_data",  int'(nrz_data),  int'(m_nrz));
            chk("R7 dclk",      int'(dclk),      int'(m_ph < bp / 2));
            chk("R4 sync_flag", int'(sync_flag), int'(m_tsync > 0));
            chk("R4 sync_pol",  int'(sync_pol),  int'(m_pol));
            chk("R6 viol_flag", int'(viol_flag), int'(m_tviol > 0));
            if (viol_flag && !pv_viol) vrise++;
            pv_viol = viol_flag;
        end else begin
            pv_viol = 0;
        end
    end

    task automatic hold(input bit lvl, input int n);
        line_in = lvl;
        repeat (n) @(negedge clk);
    endtask

    function automatic int jit_off(input int r, input int a);
        return (r % 3 == 0) ? a : ((r % 3 == 1) ? -a : 0);
    endfunction

    task automatic send_frame(input bit pos, input logic [15:0] word_in, input int jit,
                              output bit last, output int vdata);
        int h, bp, v0, idx, r;
        logic [15:0] word;
        bit halves[$];
        bp   = rate_wide ? 32 : 16;
        h    = bp / 2;
        word = word_in;
        word[15] = !pos;
        hold(!pos, bp);
        hold(pos, 3 * h + jit);
        v0 = vrise;
        for (int i = 15; i >= 0; i--) begin
            halves.push_back(word[i]);
            halves.push_back(!word[i]);
        end
        idx = 0;
        r   = 1;
        while (idx < halves.size()) begin
            bit lvl;
            int cnt;
            lvl = halves[idx];
            cnt = 0;
            while (idx < halves.size() && halves[idx] == lvl) begin
                cnt++;
                idx++;
            end
            hold(lvl, cnt * h + jit_off(r, jit));
            r++;
        end
        last  = word[0];
        vdata = vrise - v0;
    endtask

    task automatic dclk_period(output int p);
        bit pv;
        while (dclk) @(negedge clk);
        while (!dclk) @(negedge clk);
        p  = 0;
        pv = 1;
        forever begin
            @(negedge clk);
            p++;
            if (dclk && !pv) break;
            pv = dclk;
        end
    endtask

    task automatic do_reset(input bit wide);
        rst = 1;
        rate_wide = wide;
        line_in = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    initial begin
        bit last;
        int vd, v0, per;
        bit keep;
        do_reset(0);
        chk("R9 nrz after reset",  int'(nrz_data),  0);
        chk("R9 dclk after reset", int'(dclk),      1);
        chk("R9 sync after reset", int'(sync_flag), 0);
        chk("R9 pol after reset",  int'(sync_pol),  0);
        chk("R9 viol after reset", int'(viol_flag), 0);

        send_frame(1, 16'h35A7, 0, last, vd);
        chk("R2 clean 16x frame violations", vd, 0);
        chk("R5 last decoded bit", int'(nrz_data), int'(last));
        chk("R4 positive sync polarity", int'(sync_pol), 1);

        send_frame(0, 16'hC93E, 2, last, vd);
        chk("R2 jittered 16x frame violations", vd, 0);
        chk("R5 last decoded bit jittered", int'(nrz_data), int'(last));
        chk("R4 negative sync polarity", int'(sync_pol), 0);

        // R6 out-of-window span while locked, then R10 spans while unlocked
        v0 = vrise;
        hold(last, 12);
        hold(!last, 8);
        for (int i = 0; i < 6; i++) hold(i % 2 == 0 ? last : !last, 8);
        hold(last, 16);
        hold(!last, 40);
        chk("R6 bad span raises violation", vrise - v0, 1);
        chk("R10 no decode while unlocked", int'(nrz_data), int'(last));

        // R6 full span straight after the sync boundary
        v0 = vrise;
        hold(0, 20);
        hold(1, 24);
        hold(0, 16);
        hold(1, 40);
        chk("R6 long span from boundary", vrise - v0, 1);
        chk("R4 sync polarity before violation", int'(sync_pol), 1);

        // R8 static line while locked
        send_frame(1, 16'h1E6B, 2, last, vd);
        chk("R2 frame before idle", vd, 0);
        dclk_period(per);
        chk("R7 free-running dclk period 16x", per, 16);
        keep = line_in;
        repeat (300) @(negedge clk);
        chk("R8 nrz held on static line", int'(nrz_data), int'(last));
        chk("R8 sync flag quiet on static line", int'(sync_flag), 0);
        chk("R8 viol flag quiet on static line", int'(viol_flag), 0);
        v0 = vrise;
        hold(!keep, 30);
        chk("R6 edge after long idle", vrise - v0, 1);

        // R1 wide rate
        do_reset(1);
        send_frame(1, 16'h2B6D, 6, last, vd);
        chk("R1 32x jittered frame violations", vd, 0);
        chk("R5 32x last bit", int'(nrz_data), int'(last));
        dclk_period(per);
        chk("R1 free-running dclk period 32x", per, 32);
        send_frame(0, 16'hA5A5, 6, last, vd);
        chk("R3 alternating bits full spans", vd, 0);
        chk("R3 last bit after full spans", int'(nrz_data), int'(last));
        chk("R4 32x negative polarity", int'(sync_pol), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule